// File: doc/BRIEF.md
# Dual-Counter PWM Timer Channel

This block is one channel of a timer/counter unit. Two 16-bit down-counters run side by side. Counter A sets the period and counter B sets the duty. Both reload on their own when A runs out. The PWM output is high while B is nonzero. It falls when B reaches zero and stays low until the next reload. Each time A underflows, a sticky event flag is set. The flag becomes an interrupt when its mask bit allows it.

The counters advance on a count strobe. That strobe comes from one of three tick sources: the bus clock (every cycle), a real-time tick or an external tick. The strobe then passes through a prescaler that divides by a power of four, from 1 to 1024. All three sources are single-cycle enables in one clock domain. Instead of clock ticks, the channel can count transitions of an input pin. The pin is synchronised first, and the control word picks rising edges, falling edges or both. A small write-only register port sets the control word and the two reload values, and clears the flag.

Register map (word addresses on `wr_addr_i`): 0 = control, 1 = reload A, 2 = reload B, 3 = flag clear. The control word uses these bits:
- bit 0: enable
- bits 2:1: source select
- bits 5:3: divider select
- bit 6: edge mode
- bits 8:7: edge select
- bit 9: interrupt mask

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, `cnt_a_o`, `cnt_b_o`, `pwm_o` and `irq_o` are all 0.
- R2: When enabled, each count strobe decrements A. A strobe with A = 0 reloads A from reload A and B from reload B, so the period is reload A + 1 strobes. With the bus source and divider 0, there is one strobe per clock.
- R3: On each strobe, B decrements while nonzero and then holds at 0 until the next reload. `pwm_o` is 1 exactly when the channel is enabled and B is nonzero.
- R4: A strobe with A = 0 sets a sticky flag. `irq_o` equals the flag AND control bit 9. Writing 1 to bit 0 at address 3 clears the flag. A set in the same cycle wins over the clear.
- R5: Control bits 2:1 select the strobe source: 0 gives every clock, 1 gives `rtc_tick_i`, 2 gives `ext_tick_i`, and 3 gives no strobes. Pulses on a source that is not selected have no effect.
- R6: Control bits 5:3 hold a value k. For k from 0 to 5, one strobe is produced per 4^k source pulses. Values 6 and 7 act as 1024. The divider restarts from zero when the channel is enabled.
- R7: With control bit 6 set, strobes come only from transitions of `edge_in_i`, which passes through two synchroniser flops. Control bits 8:7 select the transitions: 1 = rising, 2 = falling, 3 = both, 0 = none. The clock source and divider are then ignored. A counted transition moves A three clocks after the pin changes.
- R8: While control bit 0 is 0, the counters hold. A control write that sets bit 0 while the channel is disabled loads A and B from the reload registers.
- R9: Writing a reload register does not change a running count. The new value is taken at the next underflow or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rtc_tick_i | input | 1 | Real-time tick enable |
| ext_tick_i | input | 1 | External tick enable |
| edge_in_i | input | 1 | Pin counted in edge mode (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register word address |
| wr_data_i | input | 16 | Register write data |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Masked underflow interrupt |
| cnt_a_o | output | 16 | Current value of counter A |
| cnt_b_o | output | 16 | Current value of counter B |

## Verification
The assertions assume these input properties:
- The tick inputs are one-cycle enables that are already in the channel's clock domain.
- Register writes are single-cycle strobes with a stable address and data.
- `edge_in_i` is the only asynchronous input, and only the synchroniser samples it.

The bench drives every input on the falling clock edge and raises each tick for exactly one cycle. It holds the pin level for several cycles between transitions, so each transition passes the synchroniser once.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 16;
  localparam int DIV_W    = 3;
  localparam int DIV_MAX  = 5;   // largest exponent: divide by 4**5
  localparam int SYNC_LEN = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELA  = 2'd1;
  localparam logic [ADDR_W-1:0] A_RELB  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR = 2'd3;

  typedef enum logic [1:0] {SRC_BUS, SRC_RTC, SRC_EXT, SRC_OFF} src_e;
  typedef enum logic [1:0] {EDG_NONE, EDG_RISE, EDG_FALL, EDG_BOTH} edg_e;

  typedef struct packed {
    logic             irq_mask;
    edg_e             edg;
    logic             edge_mode;
    logic [DIV_W-1:0] div;
    src_e             src;
    logic             en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W   = 3,
  parameter int DIV_MAX = 5,
  localparam int PRE_W  = 2 * DIV_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             src_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  // limit = 4**k - 1, built as k pairs of ones
  always_comb begin
    limit = '0;
    for (int i = 0; i < DIV_MAX; i++)
      if (int'(div_i) > i) limit[2*i +: 2] = 2'b11;
  end

  assign tick_o = src_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (src_i)  cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  p_tick_needs_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> src_i);
  p_clear_restarts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_edge_detect.sv
module pwm_edge_detect
  import pwm_timer_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  edg_e sel_i,
  output logic edge_o
);
  logic [SYNC:0] sh_q;
  logic lvl, prev, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC-1:0], pin_i};
  end

  assign lvl  = sh_q[SYNC-1];
  assign prev = sh_q[SYNC];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    unique case (sel_i)
      EDG_RISE: edge_o = rise;
      EDG_FALL: edge_o = fall;
      EDG_BOTH: edge_o = rise | fall;
      default:  edge_o = 1'b0;
    endcase
  end

  p_edge_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !(rise && $past(rise)) && !(fall && $past(fall)));
endmodule

// File: rtl/pwm_counter_pair.sv
module pwm_counter_pair #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         tick_i,
  input  logic [W-1:0] rel_a_i,
  input  logic [W-1:0] rel_b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         uf_o
);
  logic [W-1:0] a_q, b_q;

  assign uf_o = tick_i && !load_i && (a_q == '0);
  assign a_o  = a_q;
  assign b_o  = b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i || uf_o) begin
      a_q <= rel_a_i;
      b_q <= rel_b_i;
    end else if (tick_i) begin
      a_q <= a_q - 1'b1;
      if (b_q != '0) b_q <= b_q - 1'b1;
    end
  end

  p_a_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && a_q != '0) |=> a_q == $past(a_q) - 1'b1);
  p_uf_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |=> (a_q == $past(rel_a_i)) && (b_q == $past(rel_b_i)));
  p_b_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_q == '0 && !load_i && !uf_o) |=> b_q == '0);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(a_q) && $stable(b_q));
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_tick_i,
  input  logic              ext_tick_i,
  input  logic              edge_in_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  cnt_a_o,
  output logic [CNT_W-1:0]  cnt_b_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] rel_a_q, rel_b_q;
  logic             flag_q;
  logic             wr_ctrl, clr_flag, load, src_pulse, pre_tick, edge_tick, tick, uf;

  assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
  assign clr_flag = wr_en_i && (wr_addr_i == A_CLEAR) && wr_data_i[0];
  assign load     = wr_ctrl && wr_data_i[0] && !ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rel_a_q <= '0;
      rel_b_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTRL:  ctrl_q  <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        A_RELA:  rel_a_q <= wr_data_i[CNT_W-1:0];
        A_RELB:  rel_b_q <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (ctrl_q.src)
      SRC_BUS: src_pulse = 1'b1;
      SRC_RTC: src_pulse = rtc_tick_i;
      SRC_EXT: src_pulse = ext_tick_i;
      default: src_pulse = 1'b0;
    endcase
  end

  pwm_prescaler #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .src_i  (src_pulse && ctrl_q.en && !ctrl_q.edge_mode),
    .div_i  (ctrl_q.div),
    .tick_o (pre_tick)
  );

  pwm_edge_detect #(.SYNC(SYNC_LEN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (edge_in_i),
    .sel_i  (ctrl_q.edg),
    .edge_o (edge_tick)
  );

  assign tick = ctrl_q.en && (ctrl_q.edge_mode ? edge_tick : pre_tick);

  pwm_counter_pair #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .tick_i  (tick),
    .rel_a_i (rel_a_q),
    .rel_b_i (rel_b_q),
    .a_o     (cnt_a_o),
    .b_o     (cnt_b_o),
    .uf_o    (uf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (uf)       flag_q <= 1'b1;   // set beats clear
    else if (clr_flag) flag_q <= 1'b0;
  end

  assign pwm_o = ctrl_q.en && (cnt_b_o != '0);
  assign irq_o = flag_q && ctrl_q.irq_mask;

  p_irq_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_q.irq_mask);
  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_flag) |=> flag_q);
  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_flag && !uf) |=> !flag_q);
  p_no_strobe_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.src == SRC_OFF && !ctrl_q.edge_mode) |-> !pre_tick);
  p_pwm_low_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> !pwm_o);
endmodule

// File: tb/pwm_timer_chan_test.sv
module pwm_timer_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc = 1'b0, ext = 1'b0, pin = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm, irq;
  logic [15:0] cnt_a, cnt_b;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pwm_timer_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .rtc_tick_i(rtc), .ext_tick_i(ext),
    .edge_in_i(pin), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pwm_o(pwm), .irq_o(irq), .cnt_a_o(cnt_a), .cnt_b_o(cnt_b)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cnt_a", cnt_a, 0);
    chk("R1 cnt_b", cnt_b, 0);
    chk("R1 pwm", pwm, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_basic;
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd2);
    chk("R8 held while off", cnt_a, 0);
    wr(2'd0, 16'h0001);
    chk("R8 load a", cnt_a, 5);
    chk("R8 load b", cnt_b, 2);
    chk("R3 pwm high", pwm, 1);
    step(1);
    chk("R2 a dec", cnt_a, 4);
    chk("R3 b dec", cnt_b, 1);
    step(1);
    chk("R3 b zero", cnt_b, 0);
    chk("R3 pwm low", pwm, 0);
    wr(2'd1, 16'd9);
    chk("R9 running a", cnt_a, 2);
    step(2);
    chk("R3 b floor", cnt_b, 0);
    chk("R2 a zero", cnt_a, 0);
    step(1);
    chk("R2 reload a new", cnt_a, 9);
    chk("R2 reload b", cnt_b, 2);
    chk("R4 irq masked", irq, 0);
    wr(2'd0, 16'h0201);
    chk("R4 sticky irq", irq, 1);
    chk("R8 no reload", cnt_a, 8);
    wr(2'd3, 16'h0001);
    chk("R4 w1c", irq, 0);
    wr(2'd0, 16'h0000);
    step(3);
    chk("R8 hold a", cnt_a, 6);
    chk("R3 pwm off", pwm, 0);
  endtask

  task automatic t_div;
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0001 | (16'd1 << 3));
    step(3);
    chk("R6 div4 wait", cnt_a, 3);
    step(1);
    chk("R6 div4 tick", cnt_a, 2);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0001 | (16'd7 << 3));
    step(1023);
    chk("R6 div1024 wait", cnt_a, 3);
    step(1);
    chk("R6 div1024 tick", cnt_a, 2);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_src;
    wr(2'd0, 16'h0001 | (16'd1 << 1));
    step(3);
    chk("R5 rtc idle", cnt_a, 3);
    ext = 1'b1; step(1); ext = 1'b0;
    chk("R5 ext ignored", cnt_a, 3);
    rtc = 1'b1; step(1); rtc = 1'b0;
    chk("R5 rtc tick", cnt_a, 2);
    wr(2'd0, 16'h0001 | (16'd2 << 1));
    rtc = 1'b1; step(1); rtc = 1'b0;
    chk("R5 rtc ignored", cnt_a, 2);
    ext = 1'b1; step(1); ext = 1'b0;
    chk("R5 ext tick", cnt_a, 1);
    wr(2'd0, 16'h0001 | (16'd3 << 1));
    rtc = 1'b1; ext = 1'b1; step(2); rtc = 1'b0; ext = 1'b0;
    chk("R5 off source", cnt_a, 1);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_edge;
    wr(2'd1, 16'd20);
    wr(2'd0, 16'h0001 | (16'd1 << 6) | (16'd1 << 7));
    chk("R7 load", cnt_a, 20);
    pin = 1'b1; step(2);
    chk("R7 sync delay", cnt_a, 20);
    step(1);
    chk("R7 rise", cnt_a, 19);
    pin = 1'b0; step(4);
    chk("R7 fall ignored", cnt_a, 19);
    wr(2'd0, 16'h0001 | (16'd1 << 6) | (16'd3 << 7));
    pin = 1'b1; step(4);
    pin = 1'b0; step(4);
    chk("R7 both", cnt_a, 17);
    wr(2'd0, 16'h0001 | (16'd1 << 6));
    pin = 1'b1; step(4);
    pin = 1'b0; step(4);
    chk("R7 none", cnt_a, 17);
    wr(2'd0, 16'h0001 | (16'd1 << 6) | (16'd2 << 7));
    pin = 1'b1; step(4);
    chk("R7 rise ignored", cnt_a, 17);
    pin = 1'b0; step(4);
    chk("R7 fall", cnt_a, 16);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_basic();
    t_div();
    t_src();
    t_edge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule